// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power states of a small 8-bit microcontroller. Software writes a pair of mode bits to request a light sleep, where only the processor clock stops, or a deep sleep, where the oscillator is switched off. The block produces the processor and peripheral clock enables from a divide-by-two toggle stage. It drives the oscillator enable and the overrides for the bus-strobe and port pins. It also watches for the events that end each sleep.

A light sleep ends on any pending interrupt whose enable bit is set, or on the hardware reset pin. A deep sleep ends only on the reset pin or on an enabled external interrupt pin. After a pin-triggered wake from deep sleep, the oscillator is enabled first. The processor clock stays held until a programmable settling count has run out. When the reset pin ends a light sleep, internal RAM writes are blocked for a fixed window while the processor may still run. The pin overrides during sleep depend on whether program memory is internal or external.

Top module: `pmc_top`

## Requirements
- R1: After rst_n is released, the block is running: osc_en is 1, bus_ovr, p0_float, p2_addr and ram_inhibit are 0, and port_hold is 4'b0000.
- R2: While the oscillator is enabled, the internal tick toggles on every clk cycle, so cpu_tick and per_tick are high on exactly half of the running cycles.
- R3: One clk edge after a write with req_idle=1 and req_pdown=0, cpu_tick stays 0, per_tick keeps toggling and osc_en stays 1.
- R4: Light sleep ends on the clock edge where (irq_pend & irq_en) is non-zero. A pending line whose enable bit is 0 has no effect.
- R5: One clk edge after a write with req_pdown=1, osc_en is 0 and both cpu_tick and per_tick stay 0.
- R6: Deep sleep ends by interrupt only when ext_int[i] and irq_en[i] are both 1 for some i in {0,1}. Bits 0 and 1 are the two external interrupt pins. Pending lines, and external pins whose enable bit is 0, leave osc_en at 0.
- R7: After a pin wake from deep sleep, osc_en is 1 from the next cycle. cpu_tick and per_tick stay 0 for stab_count+1 cycles, and cpu_tick then rises within two further cycles.
- R8: A write with both req_idle and req_pdown set enters deep sleep.
- R9: hw_rst ends deep sleep on the next edge with no settling delay: osc_en returns to 1, the overrides drop and ram_inhibit stays 0.
- R10: When hw_rst ends light sleep, ram_inhibit is 1 for exactly RST_WIN cycles, starting one cycle later. bus_ovr is 0 and port_hold is 0 in that window, and cpu_tick keeps running.
- R11: In light sleep, bus_ovr=1 and bus_lvl=1. With ext_prog=0, port_hold=4'b1111 and p0_float=p2_addr=0. With ext_prog=1, p0_float=1, p2_addr=1 and port_hold=4'b1010 (bit i is port i).
- R12: In deep sleep, bus_ovr=1 and bus_lvl=0, and p2_addr=0. With ext_prog=0, port_hold=4'b1111 and p0_float=0. With ext_prog=1, p0_float=1 and port_hold=4'b1110.
- R13: The sleep request clears on wake-up: with no new write, the block stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| req_wr | input | 1 | Strobe for a write of the mode bits |
| req_idle | input | 1 | Light-sleep request bit |
| req_pdown | input | 1 | Deep-sleep request bit |
| irq_en | input | NIRQ | Interrupt enable mask; bits 0 and 1 belong to the external pins |
| irq_pend | input | NIRQ | Pending interrupt lines |
| ext_int | input | N_EXT | External interrupt pin levels, active high |
| hw_rst | input | 1 | Hardware reset pin, synchronised, active high |
| ext_prog | input | 1 | 1 when program memory is external |
| stab_count | input | CNT_W | Oscillator settling count after a pin wake |
| cpu_tick | output | 1 | Processor clock enable |
| per_tick | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_ovr | output | 1 | Address-strobe and fetch-strobe pins are forced |
| bus_lvl | output | 1 | Level forced on the strobe pins |
| p0_float | output | 1 | Port 0 is released to high impedance |
| p2_addr | output | 1 | Port 2 drives the high address byte |
| port_hold | output | 4 | Per-port hold of the data latch |
| ram_inhibit | output | 1 | Internal RAM writes are blocked |

## Verification
The bench builds the block with NIRQ=5, CNT_W=8 and RST_WIN=4. The short reset window lets the test count the exact number of inhibit cycles and see the window close. The narrow counter lets it run settling counts of 0 and 3, so both the minimum single-cycle settle and a multi-cycle one are timed edge by edge. Five interrupt lines leave three lines that are not external pins. These are used to show that pending non-pin interrupts cannot end a deep sleep.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes: four ports, numbered 0..3, with bit i of a port vector meaning port i.
package pmc_pkg;
    localparam int NUM_PORTS = 4;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2,
        PM_STAB  = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic                 bus_ovr;
        logic                 bus_lvl;
        logic                 p0_float;
        logic                 p2_addr;
        logic [NUM_PORTS-1:0] port_hold;
    } pin_ovr_t;
endpackage

// File: rtl/pmc_clkdiv.sv
// Divide-by-two toggle stage that forms the internal machine tick from the oscillator clock.
// The duty cycle of clk is irrelevant. Assumes the oscillator is stopped whenever osc_run is 0,
// so the phase is frozen then.
module pmc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    output logic tick
);
    logic div_q;

    // Toggle the phase on every oscillator cycle while the oscillator runs.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= 1'b0;
        else if (osc_run) div_q <= ~div_q;
    end

    assign tick = div_q;

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_run |=> (div_q != $past(div_q)));
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> $stable(div_q));
endmodule

// File: rtl/pmc_wake.sv
// Wake-source qualification. Light sleep may end on any enabled pending line.
// Deep sleep may end only on an enabled external pin.
// Assumes that bits 0..N_EXT-1 of irq_en are the enables of the external pins.
module pmc_wake #(
    parameter int NIRQ  = 5,
    parameter int N_EXT = 2
) (
    input  logic [NIRQ-1:0]  irq_en,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [N_EXT-1:0] ext_int,
    output logic             idle_wake,
    output logic             pdown_wake
);
    logic [N_EXT-1:0] pin_hit;

    // One qualifier per external pin; the pins are read raw because clocks are stopped in deep sleep.
    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        assign pin_hit[i] = ext_int[i] & irq_en[i];
    end

    assign pdown_wake = |pin_hit;
    assign idle_wake  = |(irq_pend & irq_en);
endmodule

// File: rtl/pmc_seq.sv
// Mode sequencer: run, light sleep, deep sleep and oscillator settle.
// It also times the RAM-write inhibit window that follows a reset-ended light sleep.
// Assumes that mode writes arrive only while running and that hw_rst is synchronous to clk.
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_WIN = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic             req_idle,
    input  logic             req_pdown,
    input  logic             hw_rst,
    input  logic             idle_wake,
    input  logic             pdown_wake,
    input  logic [CNT_W-1:0] stab_count,
    output pm_state_e        state,
    output logic             ram_inhibit
);
    localparam int WIN_W = $clog2(RST_WIN + 1);

    pm_state_e        state_q, state_d;
    logic [CNT_W-1:0] stab_q, stab_d;
    logic [WIN_W-1:0] win_q, win_d;

    // Next-state and settle-count selection; a deep-sleep request outranks a light-sleep one.
    always_comb begin
        state_d = state_q;
        stab_d  = stab_q;
        unique case (state_q)
            PM_RUN: begin
                if (req_wr && !hw_rst) begin
                    if (req_pdown)     state_d = PM_PDOWN;
                    else if (req_idle) state_d = PM_IDLE;
                end
            end
            PM_IDLE: begin
                if (hw_rst || idle_wake) state_d = PM_RUN;
            end
            PM_PDOWN: begin
                if (hw_rst) state_d = PM_RUN;
                else if (pdown_wake) begin
                    state_d = PM_STAB;
                    stab_d  = stab_count;
                end
            end
            PM_STAB: begin
                if (hw_rst || stab_q == '0) state_d = PM_RUN;
                else                        stab_d  = stab_q - 1'b1;
            end
            default: state_d = PM_RUN;
        endcase
    end

    // Inhibit window: loaded when the reset pin ends light sleep, then counted down to zero.
    always_comb begin
        if (state_q == PM_IDLE && hw_rst) win_d = WIN_W'(RST_WIN);
        else if (win_q != '0)             win_d = win_q - 1'b1;
        else                              win_d = win_q;
    end

    // State, settle counter and window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
            stab_q  <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            stab_q  <= stab_d;
            win_q   <= win_d;
        end
    end

    assign state       = state_q;
    assign ram_inhibit = (win_q != '0);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && !hw_rst && !idle_wake) |=> state_q == PM_IDLE);
    assert_pdown_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_PDOWN && !hw_rst && !pdown_wake) |=> state_q == PM_PDOWN);
    assert_stab_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STAB && stab_q != '0 && !hw_rst) |=> state_q == PM_STAB);
    assert_pdown_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && req_wr && req_pdown && !hw_rst) |=> state_q == PM_PDOWN);
    assert_reset_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_RUN && hw_rst) |=> state_q == PM_RUN);
    assert_inhibit_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_inhibit) |-> ($past(state_q) == PM_IDLE && $past(hw_rst)));
endmodule

// File: rtl/pmc_pins.sv
// Pin override decode from the sleep state and the program-memory location.
// Assumes that the settle phase keeps the deep-sleep pin levels until the processor is released.
module pmc_pins
    import pmc_pkg::*;
(
    input  pm_state_e state,
    input  logic      ext_prog,
    output pin_ovr_t  ovr
);
    // Select the override set for the current mode and memory location.
    always_comb begin
        ovr = '0;
        unique case (state)
            PM_IDLE: begin
                ovr.bus_ovr   = 1'b1;
                ovr.bus_lvl   = 1'b1;
                ovr.p0_float  = ext_prog;
                ovr.p2_addr   = ext_prog;
                ovr.port_hold = ext_prog ? 4'b1010 : 4'b1111;
            end
            PM_PDOWN, PM_STAB: begin
                ovr.bus_ovr   = 1'b1;
                ovr.bus_lvl   = 1'b0;
                ovr.p0_float  = ext_prog;
                ovr.port_hold = ext_prog ? 4'b1110 : 4'b1111;
            end
            default: ovr = '0;
        endcase
    end

    // Port 0 may not be held and released at once, and port 2 cannot carry both address and data.
    always_comb begin
        assert_p0_exclusive_R11: assert (!(ovr.p0_float && ovr.port_hold[0]));
        assert_p2_exclusive_R12: assert (!(ovr.p2_addr && ovr.port_hold[2]));
    end
endmodule

// File: rtl/pmc_top.sv
// Power mode controller top: ties together the divider, the wake qualifier, the sequencer and the pin decode,
// and gates the processor and peripheral clock enables.
// Assumes that clk is the oscillator clock and that osc_en switches the oscillator off outside this block.
module pmc_top
    import pmc_pkg::*;
#(
    parameter int NIRQ    = 5,
    parameter int N_EXT   = 2,
    parameter int CNT_W   = 16,
    parameter int RST_WIN = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic             req_idle,
    input  logic             req_pdown,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [N_EXT-1:0] ext_int,
    input  logic             hw_rst,
    input  logic             ext_prog,
    input  logic [CNT_W-1:0] stab_count,
    output logic             cpu_tick,
    output logic             per_tick,
    output logic             osc_en,
    output logic             bus_ovr,
    output logic             bus_lvl,
    output logic             p0_float,
    output logic             p2_addr,
    output logic [3:0]       port_hold,
    output logic             ram_inhibit
);
    pm_state_e state;
    pin_ovr_t  ovr;
    logic      tick, idle_wake, pdown_wake;

    pmc_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_run (osc_en),
        .tick    (tick)
    );

    pmc_wake #(.NIRQ(NIRQ), .N_EXT(N_EXT)) u_wake (
        .irq_en     (irq_en),
        .irq_pend   (irq_pend),
        .ext_int    (ext_int),
        .idle_wake  (idle_wake),
        .pdown_wake (pdown_wake)
    );

    pmc_seq #(.CNT_W(CNT_W), .RST_WIN(RST_WIN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_wr      (req_wr),
        .req_idle    (req_idle),
        .req_pdown   (req_pdown),
        .hw_rst      (hw_rst),
        .idle_wake   (idle_wake),
        .pdown_wake  (pdown_wake),
        .stab_count  (stab_count),
        .state       (state),
        .ram_inhibit (ram_inhibit)
    );

    pmc_pins u_pins (
        .state    (state),
        .ext_prog (ext_prog),
        .ovr      (ovr)
    );

    // Clock gating: the processor runs only in run; peripherals also run in light sleep.
    always_comb begin
        osc_en   = (state != PM_PDOWN);
        cpu_tick = tick && (state == PM_RUN);
        per_tick = tick && (state == PM_RUN || state == PM_IDLE);
    end

    assign bus_ovr   = ovr.bus_ovr;
    assign bus_lvl   = ovr.bus_lvl;
    assign p0_float  = ovr.p0_float;
    assign p2_addr   = ovr.p2_addr;
    assign port_hold = ovr.port_hold;

    assert_idle_periph_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_IDLE && $past(state == PM_IDLE)) |-> (per_tick != $past(per_tick)));
    assert_settle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STAB) |-> (osc_en && !cpu_tick && !per_tick));
    assert_window_ports_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_inhibit |-> (!bus_ovr && port_hold == 4'b0000));
endmodule

// File: tb/pmc_top_tb.sv
// Directed bench for the power mode controller. Inputs change on the falling edge
// and outputs are sampled on the falling edge.
module pmc_top_tb;
    localparam int NIRQ = 5, N_EXT = 2, CNT_W = 8, RST_WIN = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_wr = 0, req_idle = 0, req_pdown = 0, hw_rst = 0, ext_prog = 0;
    logic [NIRQ-1:0] irq_en = '0, irq_pend = '0;
    logic [N_EXT-1:0] ext_int = '0;
    logic [CNT_W-1:0] stab_count = '0;
    logic cpu_tick, per_tick, osc_en, bus_ovr, bus_lvl, p0_float, p2_addr, ram_inhibit;
    logic [3:0] port_hold;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    pmc_top #(.NIRQ(NIRQ), .N_EXT(N_EXT), .CNT_W(CNT_W), .RST_WIN(RST_WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_idle(req_idle), .req_pdown(req_pdown),
        .irq_en(irq_en), .irq_pend(irq_pend), .ext_int(ext_int), .hw_rst(hw_rst),
        .ext_prog(ext_prog), .stab_count(stab_count), .cpu_tick(cpu_tick), .per_tick(per_tick),
        .osc_en(osc_en), .bus_ovr(bus_ovr), .bus_lvl(bus_lvl), .p0_float(p0_float),
        .p2_addr(p2_addr), .port_hold(port_hold), .ram_inhibit(ram_inhibit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_ticks(input int n, output int c, output int p);
        c = 0; p = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(cpu_tick);
            p += int'(per_tick);
        end
    endtask

    task automatic write_mode(input logic idl, input logic pd);
        @(negedge clk);
        req_wr = 1; req_idle = idl; req_pdown = pd;
        @(negedge clk);
        req_wr = 0; req_idle = 0; req_pdown = 0;
    endtask

    task automatic t_reset;
        int c, p;
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 overrides", int'({bus_ovr, p0_float, p2_addr, port_hold}), 0);
        chk("R1 ram_inhibit", int'(ram_inhibit), 0);
        count_ticks(8, c, p);
        chk("R2 cpu ticks", c, 4);
        chk("R2 per ticks", p, 4);
    endtask

    task automatic t_idle(input logic ext);
        int c, p;
        ext_prog = ext;
        write_mode(1, 0);
        chk("R3 osc_en", int'(osc_en), 1);
        chk("R11 bus", int'({bus_ovr, bus_lvl}), 3);
        chk("R11 ports", int'({p0_float, p2_addr, port_hold}), ext ? 6'b11_1010 : 6'b00_1111);
        count_ticks(8, c, p);
        chk("R3 cpu ticks", c, 0);
        chk("R3 per ticks", p, 4);
        irq_pend = 5'b01000; irq_en = 5'b10111;
        count_ticks(4, c, p);
        chk("R4 disabled line ignored", c, 0);
        irq_en = 5'b01000;
        count_ticks(8, c, p);
        chk("R4 wake on enabled line", c, 4);
        irq_pend = '0; irq_en = '0;
        count_ticks(8, c, p);
        chk("R13 stays running", c, 4);
        ext_prog = 0;
    endtask

    task automatic t_pdown(input logic ext, input int s);
        int c, p, bad;
        ext_prog = ext; stab_count = CNT_W'(s);
        write_mode(0, 1);
        chk("R5 osc_en", int'(osc_en), 0);
        chk("R12 bus", int'({bus_ovr, bus_lvl}), 2);
        chk("R12 ports", int'({p0_float, p2_addr, port_hold}), ext ? 6'b10_1110 : 6'b00_1111);
        count_ticks(8, c, p);
        chk("R5 ticks stopped", c + p, 0);
        irq_pend = '1; irq_en = 5'b11100; ext_int = 2'b11;
        bad = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); bad += int'(osc_en); end
        chk("R6 no wake from other sources", bad, 0);
        irq_pend = '0; irq_en = 5'b00010;
        bad = 0;
        for (int i = 0; i < s + 1; i++) begin
            @(negedge clk);
            ext_int = '0;
            if (!osc_en || cpu_tick || per_tick) bad++;
        end
        chk("R7 settle window quiet", bad, 0);
        count_ticks(2, c, p);
        chk("R7 cpu released", int'(c > 0), 1);
        irq_en = '0; ext_prog = 0;
    endtask

    task automatic t_both_then_reset;
        int c, p;
        write_mode(1, 1);
        chk("R8 deep sleep wins", int'(osc_en), 0);
        @(negedge clk); hw_rst = 1;
        @(negedge clk); hw_rst = 0;
        chk("R9 osc back", int'(osc_en), 1);
        chk("R9 overrides drop", int'(bus_ovr), 0);
        chk("R9 no inhibit", int'(ram_inhibit), 0);
        count_ticks(4, c, p);
        chk("R9 no settle", c, 2);
    endtask

    task automatic t_reset_idle;
        int inh, c;
        write_mode(1, 0);
        @(negedge clk); hw_rst = 1;
        @(negedge clk); hw_rst = 0;
        chk("R10 ports released", int'({bus_ovr, port_hold}), 0);
        inh = int'(ram_inhibit); c = int'(cpu_tick);
        for (int i = 0; i < RST_WIN + 2; i++) begin
            @(negedge clk);
            inh += int'(ram_inhibit); c += int'(cpu_tick);
        end
        chk("R10 inhibit length", inh, RST_WIN);
        chk("R10 cpu runs", int'(c > 0), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle(0);
        t_idle(1);
        t_pdown(0, 3);
        t_pdown(1, 0);
        t_both_then_reset();
        t_reset_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule